// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is a synthesizable I2C slave that answers as a byte-wide serial EEPROM. The array is split into two equal halves, and a bit in the control byte chooses the half. A bus master addresses the device with a control byte. That byte holds a fixed family nibble, the half-select bit, two chip-select bits compared against strap inputs, and a read/write flag. A write then carries a two-byte memory address followed by data. A read uses an internal address counter that is kept across transactions.

Writes are gathered in a page buffer and only reach the array after the master sends STOP. The device then runs an internal write cycle. During that cycle it drives nothing and answers no control byte, so the master can poll for completion. Reads come in three kinds. A current-address read starts at the counter. A random read is an address-only write followed by a current-address read. A sequential read keeps going while the master acknowledges each byte. The counter wraps inside the selected half. Each half holds 2^HALF_AW bytes: the full-size part uses HALF_AW = 15, and the default is smaller so the array stays small in simulation.

The controlling state machine has these states: IDLE, CTRL (receiving the control byte), CTRL_ACK, AHI (high address byte), AHI_ACK, ALO (low address byte), ALO_ACK, WDATA (receiving data), WD_ACK, RDATA (sending data), RD_ACK (sampling the master's acknowledge), COMMIT (copying the page buffer to the array) and BUSY (internal write time). Its transitions are as follows:
- START in any state except COMMIT and BUSY leads to CTRL.
- From CTRL, a matching control byte leads to CTRL_ACK and a mismatch leads to IDLE.
- From CTRL_ACK, the path goes to RDATA for a read and to AHI for a write.
- The write path runs AHI → AHI_ACK → ALO → ALO_ACK → WDATA ⇄ WD_ACK.
- The read path runs RDATA → RD_ACK, then back to RDATA if the master acknowledges, or to IDLE if it does not.
- STOP leads to COMMIT if data bytes are pending, and to IDLE otherwise.
- COMMIT leads to BUSY after one pass over the page, and BUSY returns to IDLE after BUSY_CYC cycles.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset the device does not drive SDA (sda_oe = 0) and waits for a START.
- R2: The device acknowledges a control byte only when bits 7:4 are 1010 and bits 2:1 equal strap_i[1:0]. Bit 3 selects the half and bit 0 is 1 for read, 0 for write. Any other control byte gets no acknowledge.
- R3: In a write, the device acknowledges the control byte, the high address byte, the low address byte and each data byte. A single data byte followed by STOP is stored at {bit 3 of the control byte, address}.
- R4: Successive data bytes of one write go to addresses whose low 6 bits increment and wrap inside the 64-byte page, and none is stored before STOP.
- R5: After a STOP that ends a write with data, the device acknowledges no control byte for the internal write time, and acknowledges again afterwards.
- R6: A write that ends with STOP after the address bytes loads the counter, leaves memory unchanged and starts no busy period.
- R7: A current-address read returns the byte at the counter and advances the counter by one.
- R8: During a read, an acknowledge from the master makes the device send the next byte. A missing acknowledge makes it release SDA.
- R9: The counter wraps from the top of a half to the bottom of the same half, in both halves.
- R10: A repeated START before STOP discards the data bytes of the write in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Sampled level of the data line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 2 | Chip-select straps compared with control bits 2:1 |

## Verification
The internal write window is the hardest state to reach on purpose from the pins. The stimulus ends a byte write with STOP and at once sends a fresh control byte. That byte must land inside the commit-plus-busy span, so it must be refused. The master then polls until the device acknowledges again. Wrap at the top of each half is reached by an address-only write to the last location, followed by a two-byte sequential read. The page wrap is reached by a page write that starts two bytes before the page end.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WD_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_COMMIT,
        ST_BUSY
    } eep_state_t;

    localparam logic [3:0] EEP_FAMILY = 4'b1010;

endpackage

// File: rtl/eep_bus_edges.sv
module eep_bus_edges #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_q,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_p;
    logic                   sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_p  <= scl_sh[SYNC_STAGES-1];
            sda_p  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_q    = scl_sh[SYNC_STAGES-1];
    assign sda_q    = sda_sh[SYNC_STAGES-1];
    assign scl_rise = scl_q & ~scl_p;
    assign scl_fall = ~scl_q & scl_p;
    assign start_c  = scl_q & scl_p & sda_p & ~sda_q;
    assign stop_c   = scl_q & scl_p & ~sda_p & sda_q;

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [PAGE_AW-1:0] wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [PAGE_AW-1:0] rd_idx,
    output logic               rd_valid,
    output logic [7:0]         rd_data
);
    localparam int DEPTH = 1 << PAGE_AW;

    logic [DEPTH-1:0] valid;
    logic [7:0]       data [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (wr_en) begin
            valid[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid[rd_idx];
    assign rd_data  = data[rd_idx];

    p_store_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> valid[$past(wr_idx)]);

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_pkg::*;
#(
    parameter int HALF_AW     = 10,
    parameter int PAGE_AW     = 6,
    parameter int BUSY_CYC    = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap_i
);
    localparam int MEM_AW = HALF_AW + 1;
    localparam int BUSY_W = $clog2(BUSY_CYC + 1);

    eep_state_t state, nx;

    logic scl_q, sda_q, scl_rise, scl_fall, start_c, stop_c;

    logic [7:0]          rx_sh;
    logic [6:0]          tx_rest;
    logic [3:0]          bitcnt;
    logic                rw_q;
    logic                blk_q;
    logic [7:0]          ahi_q;
    logic [HALF_AW-1:0]  ctr;
    logic                ack_seen;
    logic                pending;
    logic [PAGE_AW-1:0]  commit_idx;
    logic [BUSY_W-1:0]   busy_cnt;

    logic                ctrl_ok;
    logic                byte_done;
    logic                in_write_cycle;
    logic                pb_wr, pb_clr, pb_valid;
    logic [7:0]          pb_data;
    logic [7:0]          mem_rd;
    logic                mem_we;

    eep_bus_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    assign ctrl_ok        = (rx_sh[7:4] == EEP_FAMILY) && (rx_sh[2:1] == strap_i);
    assign byte_done      = scl_fall && (bitcnt == 4'd8);
    assign in_write_cycle = (state == ST_COMMIT) || (state == ST_BUSY);

    assign pb_wr  = (state == ST_WDATA) && byte_done;
    assign pb_clr = (start_c && !in_write_cycle) ||
                    ((state == ST_COMMIT) && (commit_idx == '1));
    assign mem_we = (state == ST_COMMIT) && pb_valid;

    eep_page_buf #(.PAGE_AW(PAGE_AW)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pb_clr),
        .wr_en    (pb_wr),
        .wr_idx   (ctr[PAGE_AW-1:0]),
        .wr_data  (rx_sh),
        .rd_idx   (commit_idx),
        .rd_valid (pb_valid),
        .rd_data  (pb_data)
    );

    eep_array #(.AW(MEM_AW)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({blk_q, ctr[HALF_AW-1:PAGE_AW], commit_idx}),
        .wdata (pb_data),
        .raddr ({blk_q, ctr}),
        .rdata (mem_rd)
    );

    // next-state logic
    always_comb begin
        nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_c) nx = ST_CTRL;
            end
            ST_COMMIT: begin
                if (commit_idx == '1) nx = ST_BUSY;
            end
            ST_BUSY: begin
                if (busy_cnt == BUSY_W'(BUSY_CYC - 1)) nx = ST_IDLE;
            end
            default: begin
                if (start_c) begin
                    nx = ST_CTRL;
                end else if (stop_c) begin
                    nx = pending ? ST_COMMIT : ST_IDLE;
                end else begin
                    case (state)
                        ST_CTRL:     if (byte_done) nx = ctrl_ok ? ST_CTRL_ACK : ST_IDLE;
                        ST_CTRL_ACK: if (scl_fall)  nx = rw_q ? ST_RDATA : ST_AHI;
                        ST_AHI:      if (byte_done) nx = ST_AHI_ACK;
                        ST_AHI_ACK:  if (scl_fall)  nx = ST_ALO;
                        ST_ALO:      if (byte_done) nx = ST_ALO_ACK;
                        ST_ALO_ACK:  if (scl_fall)  nx = ST_WDATA;
                        ST_WDATA:    if (byte_done) nx = ST_WD_ACK;
                        ST_WD_ACK:   if (scl_fall)  nx = ST_WDATA;
                        ST_RDATA:    if (scl_fall && bitcnt == 4'd7) nx = ST_RD_ACK;
                        ST_RD_ACK:   if (scl_fall)  nx = ack_seen ? ST_RDATA : ST_IDLE;
                        default:     nx = state;
                    endcase
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh      <= '0;
            tx_rest    <= '0;
            bitcnt     <= '0;
            rw_q       <= 1'b0;
            blk_q      <= 1'b0;
            ahi_q      <= '0;
            ctr        <= '0;
            ack_seen   <= 1'b0;
            pending    <= 1'b0;
            commit_idx <= '0;
            busy_cnt   <= '0;
            sda_oe     <= 1'b0;
        end else if (state == ST_COMMIT) begin
            commit_idx <= commit_idx + 1'b1;
            if (commit_idx == '1) begin
                busy_cnt <= '0;
                pending  <= 1'b0;
            end
        end else if (state == ST_BUSY) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else if (start_c) begin
            bitcnt  <= '0;
            pending <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (stop_c) begin
            sda_oe     <= 1'b0;
            commit_idx <= '0;
        end else begin
            unique case (state)
                ST_CTRL, ST_AHI, ST_ALO, ST_WDATA: begin
                    if (scl_rise && bitcnt != 4'd8) begin
                        rx_sh  <= {rx_sh[6:0], sda_q};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        sda_oe <= 1'b1;
                        unique case (state)
                            ST_CTRL: begin
                                sda_oe <= ctrl_ok;
                                rw_q   <= rx_sh[0];
                                blk_q  <= rx_sh[3];
                            end
                            ST_AHI:  ahi_q <= rx_sh;
                            ST_ALO:  ctr   <= HALF_AW'({ahi_q, rx_sh});
                            default: begin
                                pending <= 1'b1;
                                ctr     <= {ctr[HALF_AW-1:PAGE_AW],
                                            PAGE_AW'(ctr[PAGE_AW-1:0] + 1'b1)};
                            end
                        endcase
                    end
                end
                ST_CTRL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WD_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        if (state == ST_CTRL_ACK && rw_q) begin
                            tx_rest <= mem_rd[6:0];
                            sda_oe  <= ~mem_rd[7];
                            ctr     <= ctr + 1'b1;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_oe   <= 1'b0;
                            ack_seen <= 1'b0;
                        end else begin
                            sda_oe  <= ~tx_rest[6];
                            tx_rest <= {tx_rest[5:0], 1'b1};
                            bitcnt  <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        ack_seen <= ~sda_q;
                    end else if (scl_fall) begin
                        bitcnt <= '0;
                        if (ack_seen) begin
                            tx_rest <= mem_rd[6:0];
                            sda_oe  <= ~mem_rd[7];
                            ctr     <= ctr + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // quiet during the internal write
    p_quiet_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_write_cycle |-> !sda_oe);

    p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> (busy_cnt < BUSY_W'(BUSY_CYC)));

    // the line is pulled only while the clock is low
    p_drive_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_q);

    p_ack_after_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && nx == ST_CTRL_ACK) |=> sda_oe);

    p_read_advances_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL_ACK && nx == ST_RDATA) |=> (ctr == $past(ctr) + 1'b1));

    p_no_busy_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_c && !pending && !in_write_cycle) |=> (state == ST_IDLE));

endmodule

// File: tb/sim_eep_i2c_slave.sv
module sim_eep_i2c_slave;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 8;
    localparam int         BUSY       = 400;
    localparam logic [1:0] STRAP      = 2'b10;

    // {address[10:0], data[7:0]}
    localparam logic [18:0] VEC [6] = '{
        {11'h000, 8'hA5}, {11'h3FF, 8'h3C}, {11'h400, 8'hC3},
        {11'h7FF, 8'h5A}, {11'h155, 8'h96}, {11'h2AA, 8'h69}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic msda = 1'b1;
    logic sda_line;
    logic sda_oe;
    int   checks = 0;
    int   errors = 0;

    assign sda_line = msda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_i2c_slave #(.BUSY_CYC(BUSY)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .strap_i (STRAP)
    );

    task automatic hq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl(input logic blk, input logic rw);
        return {4'b1010, blk, STRAP, rw};
    endfunction

    task automatic bus_start();
        msda = 1'b1; hq(Q); scl = 1'b1; hq(Q);
        msda = 1'b0; hq(Q); scl = 1'b0; hq(Q);
    endtask

    task automatic bus_stop();
        msda = 1'b0; hq(Q); scl = 1'b1; hq(Q); msda = 1'b1; hq(Q);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            msda = b[i]; hq(Q); scl = 1'b1; hq(2*Q); scl = 1'b0; hq(Q);
        end
        msda = 1'b1; hq(Q); scl = 1'b1; hq(Q);
        ack = ~sda_line;
        hq(Q); scl = 1'b0; hq(Q);
    endtask

    task automatic recv(input logic give_ack, output logic [7:0] b);
        msda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hq(Q); scl = 1'b1; hq(Q); b[i] = sda_line; hq(Q); scl = 1'b0;
        end
        msda = ~give_ack; hq(Q); scl = 1'b1; hq(2*Q); scl = 1'b0; hq(Q);
        msda = 1'b1;
    endtask

    task automatic set_addr(input logic [10:0] a, output logic ok);
        logic k1, k2, k3;
        bus_start();
        send(ctl(a[10], 1'b0), k1);
        send({6'b0, a[9:8]}, k2);
        send(a[7:0], k3);
        ok = k1 & k2 & k3;
    endtask

    task automatic rand_read(input logic [10:0] a, output logic [7:0] d);
        logic ok, k;
        set_addr(a, ok);
        bus_stop();
        bus_start();
        send(ctl(a[10], 1'b1), k);
        recv(1'b0, d);
        bus_stop();
    endtask

    task automatic poll_ready(output int tries);
        logic k;
        tries = 0;
        do begin
            bus_start();
            send(ctl(1'b0, 1'b0), k);
            bus_stop();
            tries++;
        end while (!k && tries < 100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic       ok, k, k2;
        logic [7:0] d;
        int         tries;

        // R1 reset state
        hq(20);
        chk("R1 oe in reset", {31'b0, sda_oe}, 32'd0);
        rst_n = 1'b1;
        hq(10);
        chk("R1 oe after reset", {31'b0, sda_oe}, 32'd0);

        // vector table: byte write, busy refusal, poll, random read back
        for (int v = 0; v < 6; v++) begin
            set_addr(VEC[v][18:8], ok);
            send(VEC[v][7:0], k);
            bus_stop();
            chk("R3 write acks", {30'b0, ok, k}, 32'd3);
            bus_start();
            send(ctl(1'b0, 1'b0), k);
            bus_stop();
            chk("R5 busy refuses", {31'b0, k}, 32'd0);
            poll_ready(tries);
            chk("R5 ready again", {31'b0, tries < 100}, 32'd1);
            rand_read(VEC[v][18:8], d);
            chk("R3 read back", {24'b0, d}, {24'b0, VEC[v][7:0]});
        end

        // R2 mismatching strap and family
        bus_start();
        send({4'b1010, 1'b0, ~STRAP, 1'b0}, k);
        bus_stop();
        chk("R2 strap mismatch", {31'b0, k}, 32'd0);
        bus_start();
        send({4'b1011, 1'b0, STRAP, 1'b0}, k);
        bus_stop();
        chk("R2 family mismatch", {31'b0, k}, 32'd0);
        chk("R2 released", {31'b0, sda_oe}, 32'd0);

        // R9 and R8: sequential read across the top of each half
        set_addr(11'h3FF, ok);
        bus_stop();
        bus_start();
        send(ctl(1'b0, 1'b1), k);
        recv(1'b1, d);
        chk("R8 first byte", {24'b0, d}, 32'h3C);
        recv(1'b0, d);
        chk("R9 lower wrap", {24'b0, d}, 32'hA5);
        chk("R8 release after nack", {31'b0, sda_oe}, 32'd0);
        bus_stop();
        set_addr(11'h7FF, ok);
        bus_stop();
        bus_start();
        send(ctl(1'b1, 1'b1), k);
        recv(1'b1, d);
        chk("R8 upper first", {24'b0, d}, 32'h5A);
        recv(1'b0, d);
        chk("R9 upper wrap", {24'b0, d}, 32'hC3);
        bus_stop();

        // R4 page write starting two bytes before the page end
        set_addr(11'h13E, ok);
        send(8'h11, k); send(8'h22, k); send(8'h33, k); send(8'h44, k2);
        bus_stop();
        chk("R4 page acks", {30'b0, k, k2}, 32'd3);
        poll_ready(tries);
        rand_read(11'h13E, d); chk("R4 offset 62", {24'b0, d}, 32'h11);
        rand_read(11'h13F, d); chk("R4 offset 63", {24'b0, d}, 32'h22);
        rand_read(11'h100, d); chk("R4 wrap to 0", {24'b0, d}, 32'h33);
        rand_read(11'h101, d); chk("R4 wrap to 1", {24'b0, d}, 32'h44);

        // R7 current-address reads after an address-only write
        set_addr(11'h100, ok);
        bus_stop();
        bus_start();
        send(ctl(1'b0, 1'b1), k);
        chk("R6 no busy after address-only", {31'b0, k}, 32'd1);
        recv(1'b0, d);
        bus_stop();
        chk("R7 current read", {24'b0, d}, 32'h33);
        bus_start();
        send(ctl(1'b0, 1'b1), k);
        recv(1'b0, d);
        bus_stop();
        chk("R7 counter advanced", {24'b0, d}, 32'h44);

        // R6 address-only write leaves memory alone
        set_addr(11'h155, ok);
        bus_stop();
        rand_read(11'h155, d);
        chk("R6 memory kept", {24'b0, d}, 32'h96);

        // R10 repeated START discards pending data
        set_addr(11'h2AA, ok);
        send(8'hEE, k);
        bus_start();
        bus_stop();
        bus_start();
        send(ctl(1'b0, 1'b0), k);
        bus_stop();
        chk("R10 no busy after abort", {31'b0, k}, 32'd1);
        rand_read(11'h2AA, d);
        chk("R10 data discarded", {24'b0, d}, 32'h69);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule